// File: doc/BRIEF.md
# Two-Phase Solenoid Note Sequencer

This block drives one solenoid through two phases. A note-on strobe raises the attack output for a set time. That time is a number of full 256-tick wraps (the coarse value) followed by a fine compare of fine+1 ticks. A selectable prescaler sets the tick rate. When the attack time runs out, the block drops attack on the same edge and starts a hold PWM. The PWM output goes high at each counter wrap and goes low when the counter reaches the duty value.

The PWM period, duty and power-of-two clock divider are captured from the configuration inputs when the update strobe is pulsed. Captured values take effect at the next wrap of the PWM counter. A note-off strobe stops both phases at once. A note-on that arrives while a note is active restarts the attack phase. Register storage and bus decoding sit outside the block. Configuration arrives as plain input values.

Top module: `note_seq`

## Requirements
- R1: After synchronous reset, `attack_o`, `hold_o` and both bits of `flags_o` are 0.
- R2: A `note_on` pulse with `note_off` low sets `attack_o` and `flags_o[0]` (attack flag) and clears `hold_o` and `flags_o[1]` on the next edge.
- R3: With coarse value C>0, fine value F and tick divider d, `attack_o` stays high for exactly (C*256+F+1)*d clock cycles.
- R4: With coarse value 0, `attack_o` stays high for exactly (F+1)*d clock cycles.
- R5: Prescale codes 1, 2, 3, 4 and 5 give tick dividers d of 1, 8, 64, 256 and 1024. The divider restarts on each note-on.
- R6: Prescale codes 0, 6 and 7 stop the tick. The attack timer keeps its state and `attack_o` stays high. Once a valid code returns, the remaining attack time runs out unchanged.
- R7: On the edge where the attack ends, the hold PWM is enabled and `flags_o[1]` (hold flag) goes high. `hold_o` goes high on that edge if the active duty is nonzero.
- R8: The PWM counter runs 0..P and wraps, so a period is (P+1)*D cycles. `hold_o` is high for duty*D cycles of each period. Duty 0 keeps it low. A duty greater than P keeps it high.
- R9: PWM divider code n in 2..15 gives D = 2^(n-1). Codes 0 and 1 give D = 1.
- R10: The duty, period and divider are captured on a `pwm_upd` pulse. They are loaded into the PWM at its start and at each wrap that happens after the capture cycle.
- R11: A `note_off` pulse clears `attack_o`, `hold_o` and `flags_o` on the next edge. It takes priority over a `note_on` in the same cycle.
- R12: A `note_on` during the hold phase disables the PWM (`hold_o` and hold flag low) until the restarted attack ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| note_on | input | 1 | Start or restart a note |
| note_off | input | 1 | Stop the note |
| pwm_upd | input | 1 | Capture duty, period and divider |
| coarse_in | input | 8 | Number of full 256-tick wraps in the attack |
| fine_in | input | 8 | Fine compare value of the attack |
| pre_code | input | 3 | Attack tick prescale code |
| duty_in | input | 8 | Hold PWM duty |
| period_in | input | 8 | Hold PWM counter top value |
| div_code | input | 4 | Hold PWM clock divider code |
| attack_o | output | 1 | Attack drive |
| hold_o | output | 1 | Hold PWM drive |
| flags_o | output | 2 | bit0 attack active, bit1 hold PWM enabled |

## Verification
Wrong internal state shows first as a change in the length of the attack pulse. A stuck coarse counter, a wrong compare in the fine phase or a prescaler off by one moves the falling edge of `attack_o` by at least one tick. The reference model catches that on the cycle where the edge should have happened. Errors in the PWM counter, divider or shadow loading show at `hold_o` within one PWM period after the handoff or after the first wrap that follows an update. A missed stop or restart shows on the very next cycle.

// File: rtl/sol_seq_pkg.sv
package sol_seq_pkg;

    localparam int VAL_W  = 8;
    localparam int PRE_CW = 3;
    localparam int PRE_W  = 10;
    localparam int DIV_CW = 4;
    localparam int DIV_W  = 2**DIV_CW - 2;

    typedef enum logic [1:0] {
        TM_OFF    = 2'd0,
        TM_COARSE = 2'd1,
        TM_FINE   = 2'd2
    } tmode_e;

    typedef struct packed {
        tmode_e           mode;
        logic [VAL_W-1:0] tcnt;
        logic [VAL_W-1:0] ccnt;
        logic             attack;
    } atk_state_t;

    typedef struct packed {
        logic [VAL_W-1:0]  duty;
        logic [VAL_W-1:0]  per;
        logic [DIV_CW-1:0] div;
    } pwm_cfg_t;

    typedef struct packed {
        logic hold_on;
        logic attack_on;
    } flags_t;

    // {valid, terminal count} for an attack prescale code
    function automatic logic [PRE_W:0] pre_limit(input logic [PRE_CW-1:0] code);
        case (code)
            3'd1:    return {1'b1, PRE_W'(0)};
            3'd2:    return {1'b1, PRE_W'(7)};
            3'd3:    return {1'b1, PRE_W'(63)};
            3'd4:    return {1'b1, PRE_W'(255)};
            3'd5:    return {1'b1, PRE_W'(1023)};
            default: return '0;
        endcase
    endfunction

    // terminal count of the PWM clock divider: 2^(code-1)-1, or 0 below code 2
    function automatic logic [DIV_W-1:0] div_limit(input logic [DIV_CW-1:0] code);
        logic [DIV_W:0] v;
        if (code < DIV_CW'(2)) return '0;
        v = ({{DIV_W{1'b0}}, 1'b1} << (code - DIV_CW'(1))) - {{DIV_W{1'b0}}, 1'b1};
        return v[DIV_W-1:0];
    endfunction

endpackage

// File: rtl/atk_tick.sv
module atk_tick
    import sol_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              run,
    input  logic [PRE_CW-1:0] code,
    output logic              tick
);
    localparam logic [PRE_W-1:0] P_ONE = PRE_W'(1);

    logic [PRE_W-1:0] cnt;
    logic [PRE_W:0]   lim;

    always_comb begin
        lim  = pre_limit(code);
        tick = run && lim[PRE_W] && (cnt == lim[PRE_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (run && lim[PRE_W])
            cnt <= tick ? '0 : cnt + P_ONE;
    end

endmodule

// File: rtl/atk_timer.sv
module atk_timer
    import sol_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic             tick,
    input  logic [VAL_W-1:0] coarse,
    input  logic [VAL_W-1:0] fine,
    output logic             attack,
    output logic             running,
    output logic             done
);
    localparam logic [VAL_W-1:0] V_ONE  = VAL_W'(1);
    localparam logic [VAL_W-1:0] V_WRAP = {VAL_W{1'b1}};

    atk_state_t       st;
    logic [VAL_W-1:0] cmp;
    logic             hit;

    always_comb begin
        cmp     = (st.mode == TM_COARSE) ? V_WRAP : fine;
        hit     = tick && (st.tcnt == cmp);
        done    = hit && (st.mode == TM_FINE) && !start && !stop;
        attack  = st.attack;
        running = (st.mode != TM_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            st <= '{mode: TM_OFF, tcnt: '0, ccnt: '0, attack: 1'b0};
        end else if (start) begin
            st.tcnt   <= '0;
            st.ccnt   <= '0;
            st.attack <= 1'b1;
            st.mode   <= (coarse != '0) ? TM_COARSE : TM_FINE;
        end else if (tick) begin
            if (hit) begin
                st.tcnt <= '0;
                if (st.mode == TM_COARSE) begin
                    st.ccnt <= st.ccnt + V_ONE;
                    if (({1'b0, st.ccnt} + {{VAL_W{1'b0}}, 1'b1}) >= {1'b0, coarse})
                        st.mode <= TM_FINE;
                end else begin
                    st.mode   <= TM_OFF;
                    st.attack <= 1'b0;
                end
            end else begin
                st.tcnt <= st.tcnt + V_ONE;
            end
        end
    end

    // R6: without a tick and without a strobe the timer holds its state
    a_r6_frozen_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick && !start && !stop) |=> ($stable(st.tcnt) && $stable(st.ccnt) && $stable(st.mode)));

endmodule

// File: rtl/hold_pwm.sv
module hold_pwm
    import sol_seq_pkg::*;
#(
    parameter logic [VAL_W-1:0]  DEF_DUTY = 8'd127,
    parameter logic [VAL_W-1:0]  DEF_PER  = 8'd254,
    parameter logic [DIV_CW-1:0] DEF_DIV  = 4'd10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              upd,
    input  logic [VAL_W-1:0]  duty_in,
    input  logic [VAL_W-1:0]  per_in,
    input  logic [DIV_CW-1:0] div_in,
    output logic              hold,
    output logic              en
);
    localparam logic [VAL_W-1:0] V_ONE = VAL_W'(1);
    localparam logic [DIV_W-1:0] D_ONE = DIV_W'(1);

    pwm_cfg_t         pend, act;
    logic [VAL_W-1:0] pcnt;
    logic [VAL_W-1:0] pnext;
    logic [DIV_W-1:0] dcnt;
    logic             ptick;

    always_comb begin
        ptick = en && (dcnt == div_limit(act.div));
        pnext = pcnt + V_ONE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend <= '{duty: DEF_DUTY, per: DEF_PER, div: DEF_DIV};
        else if (upd)
            pend <= '{duty: duty_in, per: per_in, div: div_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= 1'b0;
            hold <= 1'b0;
            pcnt <= '0;
            dcnt <= '0;
            act  <= '{duty: DEF_DUTY, per: DEF_PER, div: DEF_DIV};
        end else if (stop) begin
            en   <= 1'b0;
            hold <= 1'b0;
        end else if (start) begin
            en   <= 1'b1;
            pcnt <= '0;
            dcnt <= '0;
            act  <= pend;
            hold <= (pend.duty != '0);
        end else if (ptick) begin
            dcnt <= '0;
            if (pcnt == act.per) begin
                pcnt <= '0;
                act  <= pend;
                hold <= (pend.duty != '0);
            end else begin
                pcnt <= pnext;
                if (pnext == act.duty)
                    hold <= 1'b0;
            end
        end else if (en) begin
            dcnt <= dcnt + D_ONE;
        end
    end

    // R8: a zero duty never drives the hold output
    a_r8_zero_duty_low: assert property (@(posedge clk) disable iff (rst)
        (en && act.duty == '0) |-> !hold);

endmodule

// File: rtl/note_seq.sv
module note_seq
    import sol_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              note_on,
    input  logic              note_off,
    input  logic              pwm_upd,
    input  logic [VAL_W-1:0]  coarse_in,
    input  logic [VAL_W-1:0]  fine_in,
    input  logic [PRE_CW-1:0] pre_code,
    input  logic [VAL_W-1:0]  duty_in,
    input  logic [VAL_W-1:0]  period_in,
    input  logic [DIV_CW-1:0] div_code,
    output logic              attack_o,
    output logic              hold_o,
    output logic [1:0]        flags_o
);
    logic   go, tick, running, done, pwm_en, pwm_stop;
    flags_t flg;

    assign go       = note_on && !note_off;
    assign pwm_stop = note_off || note_on;

    atk_tick u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (go),
        .run  (running),
        .code (pre_code),
        .tick (tick)
    );

    atk_timer u_atk (
        .clk     (clk),
        .rst     (rst),
        .start   (go),
        .stop    (note_off),
        .tick    (tick),
        .coarse  (coarse_in),
        .fine    (fine_in),
        .attack  (attack_o),
        .running (running),
        .done    (done)
    );

    hold_pwm u_pwm (
        .clk     (clk),
        .rst     (rst),
        .start   (done),
        .stop    (pwm_stop),
        .upd     (pwm_upd),
        .duty_in (duty_in),
        .per_in  (period_in),
        .div_in  (div_code),
        .hold    (hold_o),
        .en      (pwm_en)
    );

    always_comb begin
        flg.attack_on = attack_o;
        flg.hold_on   = pwm_en;
        flags_o       = flg;
    end

    // R2: note-on raises attack and drops hold
    a_r2_note_on_attack: assert property (@(posedge clk) disable iff (rst)
        go |=> (attack_o && !hold_o));

    // R11: note-off clears every output
    a_r11_note_off_clears: assert property (@(posedge clk) disable iff (rst)
        note_off |=> (!attack_o && !hold_o && flags_o == 2'b00));

    // R12: attack and hold phases never overlap
    a_r12_phases_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(attack_o && pwm_en));

    // R7: a natural end of attack hands off to the hold PWM
    a_r7_handoff: assert property (@(posedge clk) disable iff (rst)
        ($fell(attack_o) && !$past(note_off) && !$past(note_on)) |-> pwm_en);

endmodule

// File: tb/note_seq_test.sv
module note_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       note_on = 1'b0, note_off = 1'b0, pwm_upd = 1'b0;
    logic [7:0] coarse_in = '0, fine_in = '0, duty_in = '0, period_in = '0;
    logic [2:0] pre_code = 3'd1;
    logic [3:0] div_code = '0;
    logic       attack_o, hold_o;
    logic [1:0] flags_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    note_seq uut (
        .clk(clk), .rst(rst), .note_on(note_on), .note_off(note_off), .pwm_upd(pwm_upd),
        .coarse_in(coarse_in), .fine_in(fine_in), .pre_code(pre_code),
        .duty_in(duty_in), .period_in(period_in), .div_code(div_code),
        .attack_o(attack_o), .hold_o(hold_o), .flags_o(flags_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_att, m_en, m_h;
    int m_pre, m_left;
    int m_dc, m_pc, m_ad, m_ap, m_adv;
    int m_pd = 127, m_pp = 254, m_pdv = 10;

    function automatic int tick_div(input int code);
        case (code)
            1: return 1;
            2: return 8;
            3: return 64;
            4: return 256;
            5: return 1024;
            default: return 0;
        endcase
    endfunction

    function automatic int pwm_div(input int code);
        return (code < 2) ? 1 : (1 << (code - 1));
    endfunction

    always @(posedge clk) begin
        int  d, dd;
        bit  t_att, t_pwm;
        d  = tick_div(int'(pre_code));
        dd = pwm_div(m_adv);
        t_att = m_att && (d != 0) && (m_pre == d - 1);
        t_pwm = m_en && (m_dc == dd - 1);
        if (rst) begin
            m_att = 0; m_en = 0; m_h = 0; m_pre = 0; m_left = 0;
            m_dc = 0; m_pc = 0; m_ad = 127; m_ap = 254; m_adv = 10;
            m_pd = 127; m_pp = 254; m_pdv = 10;
        end else begin
            if (note_off) begin
                m_att = 0; m_en = 0; m_h = 0;
            end else if (note_on) begin
                m_att = 1; m_pre = 0; m_en = 0; m_h = 0;
                m_left = int'(coarse_in) * 256 + int'(fine_in) + 1;
            end else if (m_att) begin
                if (d != 0) begin
                    if (t_att) begin
                        m_pre = 0;
                        m_left--;
                        if (m_left == 0) begin
                            m_att = 0; m_en = 1; m_pc = 0; m_dc = 0;
                            m_ad = m_pd; m_ap = m_pp; m_adv = m_pdv;
                            m_h = (m_ad != 0);
                        end
                    end else m_pre++;
                end
            end else if (m_en) begin
                if (t_pwm) begin
                    m_dc = 0;
                    if (m_pc == m_ap) begin
                        m_pc = 0; m_ad = m_pd; m_ap = m_pp; m_adv = m_pdv;
                        m_h = (m_ad != 0);
                    end else begin
                        m_pc++;
                        if (m_pc == m_ad) m_h = 0;
                    end
                end else m_dc++;
            end
            if (pwm_upd) begin
                m_pd = int'(duty_in); m_pp = int'(period_in); m_pdv = int'(div_code);
            end
        end
    end

    // per-cycle comparison against the model (R3/R8 timing, R7/R12 flags)
    always @(negedge clk) begin
        if (!rst) begin
            chk("R3 attack vs model", int'(attack_o), int'(m_att));
            chk("R8 hold vs model",   int'(hold_o),   int'(m_h));
            chk("R7 flags vs model",  int'(flags_o),  int'({m_en, m_att}));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic pulse_on();
        note_on = 1'b1; @(negedge clk); note_on = 1'b0;
    endtask

    task automatic pulse_off();
        note_off = 1'b1; @(negedge clk); note_off = 1'b0;
    endtask

    task automatic load_pwm(input int du, input int pe, input int dv);
        duty_in = 8'(du); period_in = 8'(pe); div_code = 4'(dv);
        pwm_upd = 1'b1; @(negedge clk); pwm_upd = 1'b0;
    endtask

    task automatic count_attack(output int len);
        len = 0;
        while (attack_o && len < 5000) begin
            len++; @(negedge clk);
        end
    endtask

    task automatic run_note(input string req, input int c, input int f, input int pc, input int exp);
        int len;
        coarse_in = 8'(c); fine_in = 8'(f); pre_code = 3'(pc);
        pulse_on();
        count_attack(len);
        chk(req, len, exp);
    endtask

    task automatic count_hold(input int win, output int hi);
        hi = 0;
        for (int i = 0; i < win; i++) begin
            if (hold_o) hi++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 8);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int len, hi;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 attack after reset", int'(attack_o), 0);
        chk("R1 hold after reset", int'(hold_o), 0);
        chk("R1 flags after reset", int'(flags_o), 0);

        // R2 then R3 (prescale 1, coarse 1, fine 3 -> 260)
        coarse_in = 8'd1; fine_in = 8'd3; pre_code = 3'd1;
        pulse_on();
        chk("R2 attack raised", int'(attack_o), 1);
        chk("R2 flags after note-on", int'(flags_o), 1);
        count_attack(len);
        chk("R3 coarse1 fine3 d1", len, 260);
        // R7: default duty 127 gives hold high on handoff
        chk("R7 hold high at handoff", int'(hold_o), 1);
        chk("R7 hold flag at handoff", int'(flags_o), 2);
        pulse_off();
        // R11
        chk("R11 hold cleared", int'(hold_o), 0);
        chk("R11 flags cleared", int'(flags_o), 0);

        run_note("R3 coarse2 fine0 d1", 2, 0, 1, 513);
        pulse_off();
        run_note("R4 coarse0 fine9 d8", 0, 9, 2, 80);
        pulse_off();
        run_note("R5 code3 d64", 0, 0, 3, 64);
        pulse_off();
        run_note("R5 code4 d256", 0, 2, 4, 768);
        pulse_off();
        run_note("R5 code5 d1024", 0, 0, 5, 1024);
        pulse_off();

        // R6: freeze by code 0, resume with code 2
        coarse_in = 8'd0; fine_in = 8'd9; pre_code = 3'd2;
        pulse_on();
        repeat (20) @(negedge clk);
        pre_code = 3'd0;
        repeat (100) @(negedge clk);
        chk("R6 attack held while frozen", int'(attack_o), 1);
        pre_code = 3'd2;
        count_attack(len);
        chk("R6 remaining after resume", len, 60);
        pulse_off();

        // R8/R9: duty 3, period 9, div code 2 (D=2)
        load_pwm(3, 9, 2);
        run_note("R4 fine0 d1", 0, 0, 1, 1);
        count_hold(20, hi);
        chk("R9 div code2 hold high", hi, 6);
        count_hold(20, hi);
        chk("R8 second period hold high", hi, 6);
        pulse_off();

        load_pwm(3, 9, 0);
        run_note("R4 fine0 d1", 0, 0, 1, 1);
        count_hold(10, hi);
        chk("R9 div code0 hold high", hi, 3);
        pulse_off();

        load_pwm(3, 9, 4);
        run_note("R4 fine0 d1", 0, 0, 1, 1);
        count_hold(80, hi);
        chk("R9 div code4 hold high", hi, 24);
        pulse_off();

        load_pwm(0, 9, 2);
        run_note("R4 fine0 d1", 0, 0, 1, 1);
        count_hold(40, hi);
        chk("R8 duty zero low", hi, 0);
        chk("R8 hold flag with duty zero", int'(flags_o), 2);
        pulse_off();

        load_pwm(12, 9, 2);
        run_note("R4 fine0 d1", 0, 0, 1, 1);
        count_hold(40, hi);
        chk("R8 duty above period high", hi, 40);
        pulse_off();

        // R10: update mid-period applies at the next wrap
        load_pwm(3, 9, 2);
        run_note("R4 fine0 d1", 0, 0, 1, 1);
        repeat (8) @(negedge clk);
        load_pwm(7, 9, 2);
        chk("R10 old duty still active", int'(hold_o), 0);
        while (hold_o == 1'b0 && flags_o[1]) @(negedge clk);
        count_hold(20, hi);
        chk("R10 new duty after wrap", hi, 14);

        // R12: restart during hold
        coarse_in = 8'd0; fine_in = 8'd4; pre_code = 3'd1;
        pulse_on();
        chk("R12 hold dropped on restart", int'(hold_o), 0);
        chk("R12 flags on restart", int'(flags_o), 1);
        count_attack(len);
        chk("R12 restarted attack length", len, 5);
        chk("R12 hold flag after restart", int'(flags_o), 2);

        // R11: note-off wins over note-on in the same cycle
        pulse_off();
        note_on = 1'b1; note_off = 1'b1;
        @(negedge clk);
        note_on = 1'b0; note_off = 1'b0;
        chk("R11 off wins over on", int'(attack_o), 0);
        chk("R11 flags after both", int'(flags_o), 0);
        repeat (4) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule